// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This unit forms the memory address for a single-register load or store. From a base register value, the address of the current instruction, a 12-bit unsigned offset with an add/subtract control, an addressing-mode select and a byte/word select, it produces three results at once, with no clock involved. The first is the effective address. The second is the value to write back into the base register, together with an enable. The third is the set of byte lanes that the access touches. The register file reads these results during the same cycle and owns the writeback itself.

A small state machine sits beside this combinational path and carries out the access on a synchronous single-port memory. It accepts a request only when it is in IDLE and moves to ISSUE. ISSUE drives the memory port for exactly one cycle and is followed by WAIT, where the read data from the memory is captured and formatted. DONE presents the response for one cycle and then returns to IDLE. Each of the transitions IDLE→ISSUE, ISSUE→WAIT, WAIT→DONE and DONE→IDLE is unconditional except the first, which requires a valid request. A word access whose low address bits are not zero is a fault. It never reaches the memory, and the fault is reported with the response.

Top module: `lsu_agen`

## Requirements
- R1: Mode code 0 (register-indirect), and the unused codes 5 to 7, give `ea` = `req_base` and `wb_en` = 0.
- R2: Mode code 1 (pre-indexed) gives `ea` = base ± offset and `wb_en` = 0.
- R3: Mode code 2 (pre-indexed with writeback) gives `ea` = base ± offset, `wb_en` = 1 and `wb_val` = `ea`.
- R4: Mode code 3 (post-indexed) gives `ea` = `req_base`, `wb_en` = 1 and `wb_val` = base ± offset.
- R5: Mode code 4 (PC-relative) gives `ea` = (`req_pc` + 8) ± offset and `wb_en` = 0.
- R6: `req_up` = 1 adds the zero-extended offset and `req_up` = 0 subtracts it. The arithmetic wraps modulo 2^32.
- R7: For a byte access, `lane_en` has only bit `ea[1:0]` set, where bit i covers data bits 8i+7:8i (little-endian). For a word access, `lane_en` is 4'b1111.
- R8: A word access with `ea[1:0]` ≠ 0 sets `misalign`. When such a request is carried out, it asserts neither `mem_en` nor `mem_we`, leaves memory unchanged, and responds with `resp_fault` = 1 and `resp_data` = 0.
- R9: A request is accepted only in IDLE. `mem_en` is high for exactly the first cycle after acceptance, `resp_valid` is high for exactly the third cycle after acceptance, and `busy` is high from acceptance until the response cycle has passed. Requests seen while `busy` is high are ignored.
- R10: A word load returns all 32 bits of the memory word. A byte load returns the selected byte zero-extended into bits 31:8.
- R11: A byte store writes only the selected lane, with `req_sdata[7:0]` placed on every lane of `mem_wdata`. A word store writes all four lanes.
- R12: After reset the unit is in IDLE, with `busy`, `mem_en`, `mem_we` and `resp_valid` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, sampled in IDLE |
| req_load | input | 1 | 1 = load, 0 = store |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| req_mode | input | 3 | Addressing mode code |
| req_up | input | 1 | 1 = add offset, 0 = subtract offset |
| req_offset | input | 12 | Unsigned immediate offset |
| req_base | input | 32 | Base register value |
| req_pc | input | 32 | Address of the current instruction |
| req_sdata | input | 32 | Store data |
| ea | output | 32 | Effective address |
| wb_en | output | 1 | Base writeback enable |
| wb_val | output | 32 | Base writeback value |
| lane_en | output | 4 | Byte lanes of the access |
| misalign | output | 1 | Word access is not word-aligned |
| busy | output | 1 | An access is in progress |
| mem_en | output | 1 | Memory port enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Memory byte address |
| mem_be | output | 4 | Memory byte-lane write enables |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after `mem_en` |
| resp_valid | output | 1 | Response strobe |
| resp_data | output | 32 | Formatted load data |
| resp_fault | output | 1 | Response reports a misaligned word access |

## Verification
Any error in the address path shows up at once on `ea`, `wb_val` or `lane_en`, in the same cycle as the inputs that caused it. Those outputs are therefore checked after a short settle delay for every mode and in both offset directions. An error in the state machine moves or stretches the `mem_en` or `resp_valid` pulse by a cycle, which can be seen within three cycles of acceptance. Errors in the latched request or in load formatting surface later, as a wrong word in memory or a wrong `resp_data`. The bench finds them by reading back the data it stored.

// File: rtl/lsu_agen_pkg.sv
package lsu_agen_pkg;

    typedef enum logic [2:0] {
        AM_INDIRECT = 3'd0,
        AM_PRE      = 3'd1,
        AM_PRE_WB   = 3'd2,
        AM_POST     = 3'd3,
        AM_PCREL    = 3'd4
    } amode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } lsu_state_e;

endpackage

// File: rtl/lsu_agen_calc.sv
module lsu_agen_calc #(
    parameter int AW      = 32,
    parameter int OW      = 12,
    parameter int PC_BIAS = 8
) (
    input  logic [2:0]    mode,
    input  logic          up,
    input  logic [OW-1:0] offset,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] pc,
    output logic [AW-1:0] ea,
    output logic [AW-1:0] wb_val,
    output logic          wb_en
);
    import lsu_agen_pkg::*;

    localparam logic [AW-1:0] BIAS = AW'(PC_BIAS);

    logic [AW-1:0] off_ext;
    logic [AW-1:0] base_step;
    logic [AW-1:0] pc_anchor;
    logic [AW-1:0] pc_step;

    assign off_ext   = {{(AW-OW){1'b0}}, offset};
    assign base_step = up ? (base + off_ext) : (base - off_ext);
    assign pc_anchor = pc + BIAS;
    assign pc_step   = up ? (pc_anchor + off_ext) : (pc_anchor - off_ext);

    always_comb begin
        ea     = base;
        wb_val = base;
        wb_en  = 1'b0;
        case (mode)
            AM_PRE: begin
                ea = base_step;
            end
            AM_PRE_WB: begin
                ea     = base_step;
                wb_val = base_step;
                wb_en  = 1'b1;
            end
            AM_POST: begin
                ea     = base;
                wb_val = base_step;
                wb_en  = 1'b1;
            end
            AM_PCREL: begin
                ea = pc_step;
            end
            default: begin
                ea = base;
            end
        endcase
    end

endmodule

// File: rtl/lsu_agen_lanes.sv
module lsu_agen_lanes #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic [AW-1:0]   addr,
    input  logic            byte_sel,
    input  logic [DW-1:0]   sdata,
    output logic [DW/8-1:0] lanes,
    output logic [DW-1:0]   wdata,
    output logic            misalign
);
    localparam int LANES = DW / 8;
    localparam int LSB_W = $clog2(LANES);

    logic [LSB_W-1:0] sel;
    assign sel      = addr[LSB_W-1:0];
    assign misalign = !byte_sel && (sel != '0);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lanes[i]         = byte_sel ? (sel == LSB_W'(i)) : 1'b1;
        assign wdata[8*i +: 8]  = byte_sel ? sdata[7:0] : sdata[8*i +: 8];
    end

endmodule

// File: rtl/lsu_agen_ldfmt.sv
module lsu_agen_ldfmt #(
    parameter int DW = 32
) (
    input  logic [DW-1:0]             rdata,
    input  logic [$clog2(DW/8)-1:0]   sel,
    input  logic                      byte_sel,
    output logic [DW-1:0]             ldata
);
    localparam int LANES = DW / 8;
    localparam int LSB_W = $clog2(LANES);

    logic [7:0] picked;

    always_comb begin
        picked = 8'h00;
        for (int i = 0; i < LANES; i++) begin
            if (sel == LSB_W'(i)) begin
                picked = rdata[8*i +: 8];
            end
        end
    end

    assign ldata = byte_sel ? {{(DW-8){1'b0}}, picked} : rdata;

endmodule

// File: rtl/lsu_agen.sv
module lsu_agen #(
    parameter int AW      = 32,
    parameter int DW      = 32,
    parameter int OW      = 12,
    parameter int PC_BIAS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_load,
    input  logic            req_byte,
    input  logic [2:0]      req_mode,
    input  logic            req_up,
    input  logic [OW-1:0]   req_offset,
    input  logic [AW-1:0]   req_base,
    input  logic [AW-1:0]   req_pc,
    input  logic [DW-1:0]   req_sdata,
    output logic [AW-1:0]   ea,
    output logic            wb_en,
    output logic [AW-1:0]   wb_val,
    output logic [DW/8-1:0] lane_en,
    output logic            misalign,
    output logic            busy,
    output logic            mem_en,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [DW/8-1:0] mem_be,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata,
    output logic            resp_valid,
    output logic [DW-1:0]   resp_data,
    output logic            resp_fault
);
    import lsu_agen_pkg::*;

    localparam int LANES = DW / 8;
    localparam int LSB_W = $clog2(LANES);

    lsu_state_e state_q, state_d;

    logic [DW-1:0]    wdata_c;
    logic             accept;

    logic [AW-1:0]    lat_addr;
    logic [LANES-1:0] lat_be;
    logic [DW-1:0]    lat_wdata;
    logic             lat_load;
    logic             lat_byte;
    logic             lat_mis;

    logic [DW-1:0]    ld_fmt;
    logic [DW-1:0]    resp_data_q;
    logic             resp_fault_q;

    lsu_agen_calc #(.AW(AW), .OW(OW), .PC_BIAS(PC_BIAS)) u_calc (
        .mode   (req_mode),
        .up     (req_up),
        .offset (req_offset),
        .base   (req_base),
        .pc     (req_pc),
        .ea     (ea),
        .wb_val (wb_val),
        .wb_en  (wb_en)
    );

    lsu_agen_lanes #(.AW(AW), .DW(DW)) u_lanes (
        .addr     (ea),
        .byte_sel (req_byte),
        .sdata    (req_sdata),
        .lanes    (lane_en),
        .wdata    (wdata_c),
        .misalign (misalign)
    );

    lsu_agen_ldfmt #(.DW(DW)) u_ldfmt (
        .rdata    (mem_rdata),
        .sel      (lat_addr[LSB_W-1:0]),
        .byte_sel (lat_byte),
        .ldata    (ld_fmt)
    );

    assign accept = (state_q == ST_IDLE) && req_valid;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_ISSUE;
            ST_ISSUE: state_d = ST_WAIT;
            ST_WAIT:  state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
        endcase
    end

    // request latch and response capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_addr     <= '0;
            lat_be       <= '0;
            lat_wdata    <= '0;
            lat_load     <= 1'b1;
            lat_byte     <= 1'b0;
            lat_mis      <= 1'b0;
            resp_data_q  <= '0;
            resp_fault_q <= 1'b0;
        end else begin
            if (accept) begin
                lat_addr  <= ea;
                lat_be    <= lane_en;
                lat_wdata <= wdata_c;
                lat_load  <= req_load;
                lat_byte  <= req_byte;
                lat_mis   <= misalign;
            end
            if (state_q == ST_WAIT) begin
                resp_data_q  <= lat_mis ? '0 : ld_fmt;
                resp_fault_q <= lat_mis;
            end
        end
    end

    // outputs per state
    always_comb begin
        mem_en     = 1'b0;
        mem_we     = 1'b0;
        resp_valid = 1'b0;
        busy       = 1'b1;
        unique case (state_q)
            ST_IDLE:  busy = 1'b0;
            ST_ISSUE: begin
                mem_en = !lat_mis;
                mem_we = !lat_mis && !lat_load;
            end
            ST_WAIT:  ;
            ST_DONE:  resp_valid = 1'b1;
        endcase
    end

    assign mem_addr   = lat_addr;
    assign mem_be     = lat_be;
    assign mem_wdata  = lat_wdata;
    assign resp_data  = resp_data_q;
    assign resp_fault = resp_fault_q;

endmodule

// File: rtl/lsu_agen_chk.sv
module lsu_agen_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  req_mode,
    input logic [31:0] req_base,
    input logic        req_byte,
    input logic [31:0] ea,
    input logic        wb_en,
    input logic [3:0]  lane_en,
    input logic        mem_en,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [3:0]  mem_be,
    input logic        resp_valid,
    input logic        busy
);
    a_r1_indirect_ea: assert property (@(posedge clk) disable iff (!rst_n)
        (req_mode == 3'd0) |-> (ea == req_base));

    a_r1_r5_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
        (req_mode == 3'd0 || req_mode == 3'd4) |-> !wb_en);

    a_r7_byte_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
        req_byte |-> ($countones(lane_en) == 1));

    a_r8_word_write_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $countones(mem_be) == 4) |-> (mem_addr[1:0] == 2'b00));

    a_r9_en_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |=> !mem_en);

    a_r9_resp_single: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    a_r9_resp_busy: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> busy);

    a_r11_we_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_en);

endmodule

bind lsu_agen lsu_agen_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_mode   (req_mode),
    .req_base   (req_base),
    .req_byte   (req_byte),
    .ea         (ea),
    .wb_en      (wb_en),
    .lane_en    (lane_en),
    .mem_en     (mem_en),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_be     (mem_be),
    .resp_valid (resp_valid),
    .busy       (busy)
);

// File: tb/sim_lsu_agen.sv
module sim_lsu_agen;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_load = 1'b1;
    logic        req_byte = 1'b0;
    logic [2:0]  req_mode = 3'd0;
    logic        req_up = 1'b1;
    logic [11:0] req_offset = '0;
    logic [31:0] req_base = '0;
    logic [31:0] req_pc = '0;
    logic [31:0] req_sdata = '0;
    logic [31:0] ea, wb_val, mem_addr, mem_wdata, resp_data;
    logic [31:0] mem_rdata = '0;
    logic        wb_en, misalign, busy, mem_en, mem_we, resp_valid, resp_fault;
    logic [3:0]  lane_en, mem_be;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] bmem [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    lsu_agen u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_load(req_load),
        .req_byte(req_byte), .req_mode(req_mode), .req_up(req_up),
        .req_offset(req_offset), .req_base(req_base), .req_pc(req_pc),
        .req_sdata(req_sdata), .ea(ea), .wb_en(wb_en), .wb_val(wb_val),
        .lane_en(lane_en), .misalign(misalign), .busy(busy), .mem_en(mem_en),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .resp_valid(resp_valid),
        .resp_data(resp_data), .resp_fault(resp_fault)
    );

    always @(posedge clk) begin
        if (mem_en) begin
            mem_rdata <= bmem[mem_addr[5:2]];
            if (mem_we) begin
                for (int i = 0; i < 4; i++) begin
                    if (mem_be[i]) bmem[mem_addr[5:2]][8*i +: 8] <= mem_wdata[8*i +: 8];
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic set_req(input logic ld, input logic by, input logic [2:0] md,
                           input logic up, input logic [11:0] off,
                           input logic [31:0] base, input logic [31:0] sd);
        req_load = ld; req_byte = by; req_mode = md; req_up = up;
        req_offset = off; req_base = base; req_sdata = sd;
    endtask

    // carries out one access; checks the R9 pulse timing
    task automatic run_acc(input logic exp_en, input logic hold,
                           output logic [31:0] rd, output logic flt);
        @(negedge clk);
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        if (hold) set_req(1'b0, 1'b0, 3'd0, 1'b1, 12'd0, 32'h0000_000C, 32'hBAD0_BAD0);
        else req_valid = 1'b0;
        chk("R9 mem_en in ISSUE", {31'b0, mem_en}, {31'b0, exp_en});
        chk("R9 busy in ISSUE", {31'b0, busy}, 32'd1);
        @(negedge clk);
        chk("R9 mem_en off in WAIT", {31'b0, mem_en}, 32'd0);
        chk("R9 no resp in WAIT", {31'b0, resp_valid}, 32'd0);
        @(negedge clk);
        chk("R9 resp_valid in DONE", {31'b0, resp_valid}, 32'd1);
        rd = resp_data; flt = resp_fault;
        req_valid = 1'b0;
        @(negedge clk);
        chk("R9 resp_valid single", {31'b0, resp_valid}, 32'd0);
        chk("R9 idle after", {31'b0, busy}, 32'd0);
    endtask

    task automatic t_reset;
        chk("R12 busy", {31'b0, busy}, 32'd0);
        chk("R12 mem_en", {31'b0, mem_en}, 32'd0);
        chk("R12 mem_we", {31'b0, mem_we}, 32'd0);
        chk("R12 resp_valid", {31'b0, resp_valid}, 32'd0);
    endtask

    task automatic t_modes;
        req_pc = 32'h0000_8000;
        set_req(1, 0, 3'd0, 1, 12'h010, 32'h0000_1000, 0); #1;
        chk("R1 indirect ea", ea, 32'h0000_1000);
        chk("R1 indirect wb_en", {31'b0, wb_en}, 0);
        set_req(1, 0, 3'd6, 1, 12'h010, 32'h0000_2000, 0); #1;
        chk("R1 unused code ea", ea, 32'h0000_2000);
        chk("R1 unused code wb_en", {31'b0, wb_en}, 0);
        set_req(1, 0, 3'd1, 1, 12'h004, 32'h0000_1000, 0); #1;
        chk("R2 pre ea", ea, 32'h0000_1004);
        chk("R2 pre wb_en", {31'b0, wb_en}, 0);
        set_req(1, 0, 3'd2, 0, 12'h100, 32'h0000_1000, 0); #1;
        chk("R3 prewb ea", ea, 32'h0000_0F00);
        chk("R3 prewb wb_val", wb_val, 32'h0000_0F00);
        chk("R3 prewb wb_en", {31'b0, wb_en}, 1);
        set_req(1, 0, 3'd3, 1, 12'hFFC, 32'h0000_1000, 0); #1;
        chk("R4 post ea", ea, 32'h0000_1000);
        chk("R4 post wb_val", wb_val, 32'h0000_1FFC);
        chk("R4 post wb_en", {31'b0, wb_en}, 1);
        set_req(1, 0, 3'd4, 1, 12'h008, 32'h0, 0); #1;
        chk("R5 pcrel up ea", ea, 32'h0000_8010);
        chk("R5 pcrel wb_en", {31'b0, wb_en}, 0);
        set_req(1, 0, 3'd4, 0, 12'h010, 32'h0, 0); #1;
        chk("R5 pcrel down ea", ea, 32'h0000_7FF8);
        set_req(1, 0, 3'd1, 0, 12'h008, 32'h0000_0004, 0); #1;
        chk("R6 subtract wraps", ea, 32'hFFFF_FFFC);
        set_req(1, 0, 3'd2, 1, 12'h008, 32'hFFFF_FFFC, 0); #1;
        chk("R6 add wraps", wb_val, 32'h0000_0004);
    endtask

    task automatic t_lanes;
        for (int i = 0; i < 4; i++) begin
            set_req(1, 1, 3'd0, 1, 0, 32'h0000_0040 + i, 0); #1;
            chk("R7 byte lane", {28'b0, lane_en}, 32'd1 << i);
            chk("R7 byte no misalign", {31'b0, misalign}, 0);
        end
        set_req(1, 0, 3'd0, 1, 0, 32'h0000_0040, 0); #1;
        chk("R7 word lanes", {28'b0, lane_en}, 32'hF);
        set_req(1, 0, 3'd1, 1, 12'h002, 32'h0000_0040, 0); #1;
        chk("R8 misalign flag", {31'b0, misalign}, 1);
    endtask

    task automatic t_word_rw;
        logic [31:0] rd; logic flt;
        set_req(0, 0, 3'd1, 1, 12'h004, 32'h0000_000C, 32'hDEAD_BEEF);
        run_acc(1, 0, rd, flt);
        chk("R11 word store", bmem[4], 32'hDEAD_BEEF);
        set_req(1, 0, 3'd3, 1, 12'h004, 32'h0000_0010, 0);
        run_acc(1, 0, rd, flt);
        chk("R10 word load", rd, 32'hDEAD_BEEF);
        chk("R10 word load no fault", {31'b0, flt}, 0);
    endtask

    task automatic t_byte;
        logic [31:0] rd; logic flt;
        @(negedge clk); bmem[8] = 32'h1122_3344;
        set_req(0, 1, 3'd2, 1, 12'h001, 32'h0000_0020, 32'h0000_77A5);
        run_acc(1, 0, rd, flt);
        chk("R11 byte store lane1", bmem[8], 32'h1122_A544);
        set_req(1, 1, 3'd0, 1, 0, 32'h0000_0021, 0);
        run_acc(1, 0, rd, flt);
        chk("R10 byte load zero-ext", rd, 32'h0000_00A5);
        set_req(1, 1, 3'd1, 0, 12'h001, 32'h0000_0024, 0);
        run_acc(1, 0, rd, flt);
        chk("R10 byte load lane3", rd, 32'h0000_0011);
    endtask

    task automatic t_misalign;
        logic [31:0] rd; logic flt;
        @(negedge clk); bmem[12] = 32'h5555_AAAA;
        set_req(0, 0, 3'd0, 1, 0, 32'h0000_0032, 32'h0BAD_F00D);
        run_acc(0, 0, rd, flt);
        chk("R8 memory untouched", bmem[12], 32'h5555_AAAA);
        chk("R8 fault", {31'b0, flt}, 1);
        chk("R8 data zero", rd, 32'h0);
    endtask

    task automatic t_busy_ignore;
        logic [31:0] rd; logic flt;
        @(negedge clk); bmem[3] = 32'h1234_5678; bmem[5] = 32'hCAFE_0001;
        set_req(1, 0, 3'd0, 1, 0, 32'h0000_0014, 0);
        run_acc(1, 1, rd, flt);
        chk("R9 first request served", rd, 32'hCAFE_0001);
        chk("R9 busy request ignored", bmem[3], 32'h1234_5678);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) bmem[i] = 32'h0;
        #(CLK_PERIOD*2 + 2);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_modes();
        t_lanes();
        t_word_rw();
        t_byte();
        t_misalign();
        t_busy_ignore();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule